// File: doc/BRIEF.md
# Index-Port Real-Time Clock Core

This block is a calendar clock that a host reaches through two byte ports. A write to the index port picks one of fourteen internal byte registers. Later reads and writes on the data port then go to that register. The block holds seconds, minutes, hours, day of week, day of month, month and a two-digit year. It advances them once for each pulse on a one-second tick input.

The time is kept directly in the encoding the host selects in control register B. That encoding is either BCD or binary, with hours either in 24-hour form or in 12-hour form with a PM flag. Counting is done correctly in whichever encoding is active. A hold bit lets the host freeze the time while it writes a consistent value.

Each accepted tick starts a short update window. The window is visible as a status bit, and the calendar step lands at its end. Every completed step sets an update-ended flag. A step whose new time matches the three alarm registers also sets an alarm flag. Reading control register C returns these flags and clears them. The interrupt output follows the enabled flags.

Top module: `rtc_ixport`

## Requirements
- R1: A write with `bus_sel`=0 loads the index. `bus_rdata` always shows the indexed register, and a write with `bus_sel`=1 stores into it. Indices 12 and above ignore writes, and indices 13 and above read as 0x00.
- R2: Register indices are 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 day of month, 8 month, 9 year, 10 control A, 11 control B, 12 control C and 13 control D.
- R3: Control A bit 7 is a read-only update-in-progress flag. It reads 1 from the cycle after an accepted tick for `UIP_LEAD` cycles and reads 0 from the cycle in which the new time appears. Control A bits 6:0 are plain storage.
- R4: While control B bit 7 (hold) is 1, ticks start no update and the time registers change only by host writes. After hold is cleared, the next tick advances from the values the host wrote.
- R5: With control B bit 2 = 0 (BCD), each field counts in BCD. The tens digit carries correctly (0x09 to 0x10), and seconds and minutes roll from 0x59 to 0x00 with a carry.
- R6: With control B bit 2 = 1 (binary), the fields count as plain binary values with the same limits (59 to 0 with a carry).
- R7: With control B bit 1 = 0 (12-hour mode), hours bit 7 is PM and bits 6:0 hold 1 to 12. The hour steps from 11 AM to 12 PM to 1 PM, and from 11 PM to 12 AM (which advances the day) to 1 AM.
- R8: With control B bit 1 = 1, hours run 0 to 23, and the step from 23 to 0 advances the day. Day of week counts 1 to 7 and wraps to 1.
- R9: Day of month wraps to 1 after the last day of its month: 30 for April, June, September and November, 28 or 29 for February, and 31 otherwise. A year value divisible by 4 is a leap year. Month wraps from 12 to 1 and increments the year, and the year wraps from 99 to 0.
- R10: Every completed update sets control C bit 4 (update ended). A data-port read strobe at index 12 clears bits 4 and 5, unless an update sets them in the same cycle.
- R11: Control C bit 5 (alarm) sets at an update when the new seconds, minutes and hours bytes equal the three alarm bytes exactly, in the active encoding.
- R12: Control C bit 7 and the `irq` output are 1 exactly when (bit 4 and control B bit 4) or (bit 5 and control B bit 5).
- R13: After reset the time reads 00:00:00, day of week 1, 1 January year 00, control B 0x02 (24-hour BCD), control C 0x00 and `irq` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_rd | input | 1 | Read strobe; matters only for a data-port read of control C |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Contents of the register named by the index |
| irq | output | 1 | Interrupt request, high while an enabled flag is set |

## Verification
The bench sets the clock to boundary instants in each of the four encodings and checks the result of one step. The cases are the end of the year, February in leap and common years, 30-day months, the BCD tens digit, and both 12-hour crossings. A design that skipped the PM bit at noon, advanced the date at noon instead of midnight, or compared day of month in the wrong encoding would show a wrong hour or date after that step. The bench also ticks with the hold bit set to catch a design that still counts. It times the update-in-progress window edge by edge, so a lead off by one cycle shows up. It reads control C twice to catch flags that do not clear, or an interrupt raised by a flag that is not enabled.

// File: rtl/rtc_ixport_pkg.sv
package rtc_ixport_pkg;

  localparam int BYTE_W = 8;

  // register indices; the host software depends on this order
  localparam logic [7:0] IX_SEC   = 8'd0;
  localparam logic [7:0] IX_ASEC  = 8'd1;
  localparam logic [7:0] IX_MIN   = 8'd2;
  localparam logic [7:0] IX_AMIN  = 8'd3;
  localparam logic [7:0] IX_HOUR  = 8'd4;
  localparam logic [7:0] IX_AHOUR = 8'd5;
  localparam logic [7:0] IX_WDAY  = 8'd6;
  localparam logic [7:0] IX_MDAY  = 8'd7;
  localparam logic [7:0] IX_MON   = 8'd8;
  localparam logic [7:0] IX_YEAR  = 8'd9;
  localparam logic [7:0] IX_CTLA  = 8'd10;
  localparam logic [7:0] IX_CTLB  = 8'd11;
  localparam logic [7:0] IX_CTLC  = 8'd12;
  localparam logic [7:0] IX_CTLD  = 8'd13;

  // control B fields
  localparam int CB_H24  = 1;
  localparam int CB_BIN  = 2;
  localparam int CB_UIE  = 4;
  localparam int CB_AIE  = 5;
  localparam int CB_HOLD = 7;
  localparam logic [7:0] CTLB_RST = 8'h02;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } tod_t;

  // stored byte -> plain number
  function automatic logic [7:0] to_num(input logic [7:0] v, input logic bin);
    return bin ? v : (8'(v[7:4]) * 8'd10 + 8'(v[3:0]));
  endfunction

  // plain number (0..99) -> stored byte
  function automatic logic [7:0] from_num(input logic [7:0] n, input logic bin);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = n / 8'd10;
    ones = n - tens * 8'd10;
    return bin ? n : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'd2:                     return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ixport_useq.sv
module rtc_ixport_useq #(
  parameter int LEAD = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick,
  input  logic hold,
  output logic uip,
  output logic upd_stb
);
  localparam int CW = $clog2(LEAD + 1);
  localparam logic [CW-1:0] LEAD_C = CW'(LEAD);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0)          cnt_d = cnt_q - 1'b1;
    else if (tick && !hold)   cnt_d = LEAD_C;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign uip     = (cnt_q != '0);
  assign upd_stb = (cnt_q == CW'(1));

  // an accepted tick opens the window on the next cycle
  assert_uip_opens_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !hold && !uip) |=> uip);
  // the window never opens without a tick
  assert_uip_cause_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(uip) |-> $past(tick));
  // a held clock starts no window
  assert_hold_no_start_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && hold && !uip) |=> !uip);

endmodule

// File: rtl/rtc_ixport_cal.sv
module rtc_ixport_cal
  import rtc_ixport_pkg::*;
(
  input  tod_t cur,
  input  logic bin_mode,
  input  logic h24_mode,
  output tod_t nxt
);
  logic [7:0] s, m, hv, h, h12, d, mo, y, wd;
  logic       c_s, c_m, c_h, c_d, c_mo, pm, leap;
  logic [7:0] hour_enc;

  always_comb begin
    nxt = cur;

    s   = to_num(cur.sec, bin_mode) + 8'd1;
    c_s = (s >= 8'd60);
    nxt.sec = from_num(c_s ? 8'd0 : s, bin_mode);

    m   = to_num(cur.min, bin_mode) + 8'(c_s);
    c_m = c_s && (m >= 8'd60);
    if (c_s) nxt.min = from_num(c_m ? 8'd0 : m, bin_mode);

    // hour as 0..23 whatever the stored form
    hv = to_num({1'b0, cur.hour[6:0]}, bin_mode);
    if (h24_mode) h = to_num(cur.hour, bin_mode);
    else          h = ((hv == 8'd12) ? 8'd0 : hv) + (cur.hour[7] ? 8'd12 : 8'd0);
    h   = h + 8'(c_m);
    c_h = c_m && (h >= 8'd24);
    if (c_h) h = 8'd0;
    pm  = (h >= 8'd12);
    h12 = pm ? (h - 8'd12) : h;
    if (h12 == 8'd0) h12 = 8'd12;
    hour_enc = h24_mode ? from_num(h, bin_mode)
                        : (from_num(h12, bin_mode) | {pm, 7'b0});
    if (c_m) nxt.hour = hour_enc;

    wd = to_num(cur.wday, bin_mode);
    wd = (wd >= 8'd7) ? 8'd1 : wd + 8'd1;
    if (c_h) nxt.wday = from_num(wd, bin_mode);

    y    = to_num(cur.year, bin_mode);
    leap = (y[1:0] == 2'b00);
    mo   = to_num(cur.mon, bin_mode);
    d    = to_num(cur.mday, bin_mode) + 8'd1;
    c_d  = c_h && (d > month_len(mo, leap));
    if (c_h) nxt.mday = from_num(c_d ? 8'd1 : d, bin_mode);

    mo   = mo + 8'd1;
    c_mo = c_d && (mo > 8'd12);
    if (c_d) nxt.mon = from_num(c_mo ? 8'd1 : mo, bin_mode);

    y = y + 8'd1;
    if (c_mo) nxt.year = from_num((y >= 8'd100) ? 8'd0 : y, bin_mode);
  end

endmodule

// File: rtl/rtc_ixport.sv
module rtc_ixport
  import rtc_ixport_pkg::*;
#(
  parameter int UIP_LEAD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [7:0] idx_q, idx_d;
  tod_t       tm_q, tm_d, cal_nxt;
  logic [7:0] asec_q, asec_d, amin_q, amin_d, ahour_q, ahour_d;
  logic [6:0] ctla_q, ctla_d;
  logic [7:0] ctlb_q, ctlb_d;
  logic       uf_q, uf_d, af_q, af_d;
  logic       uip, upd_stb, upd_go, alm_hit, irqf;
  logic       idx_wr, data_wr, c_rd;

  assign idx_wr  = bus_wr && !bus_sel;
  assign data_wr = bus_wr &&  bus_sel;
  assign c_rd    = bus_rd &&  bus_sel && (idx_q == IX_CTLC);

  rtc_ixport_useq #(.LEAD(UIP_LEAD)) u_useq (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .tick    (sec_tick),
    .hold    (ctlb_q[CB_HOLD]),
    .uip     (uip),
    .upd_stb (upd_stb)
  );

  rtc_ixport_cal u_cal (
    .cur      (tm_q),
    .bin_mode (ctlb_q[CB_BIN]),
    .h24_mode (ctlb_q[CB_H24]),
    .nxt      (cal_nxt)
  );

  // hold raised during a window cancels its step
  assign upd_go  = upd_stb && !ctlb_q[CB_HOLD];
  assign alm_hit = (cal_nxt.sec == asec_q) && (cal_nxt.min == amin_q) &&
                   (cal_nxt.hour == ahour_q);

  always_comb begin
    idx_d   = idx_wr ? bus_wdata : idx_q;
    tm_d    = upd_go ? cal_nxt : tm_q;
    asec_d  = asec_q;
    amin_d  = amin_q;
    ahour_d = ahour_q;
    ctla_d  = ctla_q;
    ctlb_d  = ctlb_q;
    if (data_wr) begin
      case (idx_q)
        IX_SEC:   tm_d.sec  = bus_wdata;
        IX_ASEC:  asec_d    = bus_wdata;
        IX_MIN:   tm_d.min  = bus_wdata;
        IX_AMIN:  amin_d    = bus_wdata;
        IX_HOUR:  tm_d.hour = bus_wdata;
        IX_AHOUR: ahour_d   = bus_wdata;
        IX_WDAY:  tm_d.wday = bus_wdata;
        IX_MDAY:  tm_d.mday = bus_wdata;
        IX_MON:   tm_d.mon  = bus_wdata;
        IX_YEAR:  tm_d.year = bus_wdata;
        IX_CTLA:  ctla_d    = bus_wdata[6:0];
        IX_CTLB:  ctlb_d    = bus_wdata;
        default:  ;
      endcase
    end
    // setting beats clear-on-read
    uf_d = upd_go ? 1'b1 : (c_rd ? 1'b0 : uf_q);
    af_d = (upd_go && alm_hit) ? 1'b1 : (c_rd ? 1'b0 : af_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      tm_q    <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                   mday: 8'h01, mon: 8'h01, year: 8'h00};
      asec_q  <= '0;
      amin_q  <= '0;
      ahour_q <= '0;
      ctla_q  <= '0;
      ctlb_q  <= CTLB_RST;
      uf_q    <= 1'b0;
      af_q    <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      tm_q    <= tm_d;
      asec_q  <= asec_d;
      amin_q  <= amin_d;
      ahour_q <= ahour_d;
      ctla_q  <= ctla_d;
      ctlb_q  <= ctlb_d;
      uf_q    <= uf_d;
      af_q    <= af_d;
    end
  end

  assign irqf = (uf_q && ctlb_q[CB_UIE]) || (af_q && ctlb_q[CB_AIE]);
  assign irq  = irqf;

  always_comb begin
    case (idx_q)
      IX_SEC:   bus_rdata = tm_q.sec;
      IX_ASEC:  bus_rdata = asec_q;
      IX_MIN:   bus_rdata = tm_q.min;
      IX_AMIN:  bus_rdata = amin_q;
      IX_HOUR:  bus_rdata = tm_q.hour;
      IX_AHOUR: bus_rdata = ahour_q;
      IX_WDAY:  bus_rdata = tm_q.wday;
      IX_MDAY:  bus_rdata = tm_q.mday;
      IX_MON:   bus_rdata = tm_q.mon;
      IX_YEAR:  bus_rdata = tm_q.year;
      IX_CTLA:  bus_rdata = {uip, ctla_q};
      IX_CTLB:  bus_rdata = ctlb_q;
      IX_CTLC:  bus_rdata = {irqf, 1'b0, af_q, uf_q, 4'b0000};
      default:  bus_rdata = 8'h00;
    endcase
  end

  // held time moves only through host writes
  assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctlb_q[CB_HOLD] && !data_wr) |=> $stable(tm_q));
  // a completed step always leaves the update-ended flag set
  assert_uf_after_step_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    upd_go |=> uf_q);
  // a read of C with no step in that cycle empties both flags
  assert_c_clears_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (c_rd && !upd_go) |=> (!uf_q && !af_q));
  // binary seconds stay inside 0..59 across a step
  assert_bin_sec_range_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (upd_go && ctlb_q[CB_BIN] && (tm_q.sec < 8'd60) && !data_wr) |=> (tm_q.sec < 8'd60));
  // the step lands while the window is still open
  assert_step_in_window_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    upd_go |-> uip);

endmodule

// File: tb/rtc_ixport_bench.sv
module rtc_ixport_bench;
  localparam int LEAD = 4;
  localparam int NV   = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rtc_ixport #(.UIP_LEAD(LEAD)) u_rtc_ixport (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // control B, sec, min, hour, wday, mday, mon, year, then expected
  // sec, min, hour, wday, mday, mon, year after one tick
  localparam logic [119:0] VECS [NV] = '{
    {8'h02, 8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}, // R5 R8 R9 year end
    {8'h02, 8'h09,8'h14,8'h05,8'h03,8'h15,8'h06,8'h24, 8'h10,8'h14,8'h05,8'h03,8'h15,8'h06,8'h24}, // R5 tens digit
    {8'h02, 8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h23}, // R9 common Feb
    {8'h02, 8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h03,8'h29,8'h02,8'h24}, // R9 leap Feb 28
    {8'h02, 8'h59,8'h59,8'h23,8'h03,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h24}, // R9 leap Feb 29
    {8'h02, 8'h59,8'h59,8'h23,8'h05,8'h30,8'h04,8'h25, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h05,8'h25}, // R9 April
    {8'h02, 8'h59,8'h59,8'h23,8'h01,8'h30,8'h01,8'h25, 8'h00,8'h00,8'h00,8'h02,8'h31,8'h01,8'h25}, // R9 January 30
    {8'h06, 8'h3B,8'h3B,8'h17,8'h07,8'h1F,8'h0C,8'h63, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}, // R6 R8 R9 binary year end
    {8'h06, 8'h09,8'h0E,8'h05,8'h03,8'h0F,8'h06,8'h18, 8'h0A,8'h0E,8'h05,8'h03,8'h0F,8'h06,8'h18}, // R6 binary 9 -> 10
    {8'h00, 8'h59,8'h59,8'h11,8'h04,8'h10,8'h05,8'h20, 8'h00,8'h00,8'h92,8'h04,8'h10,8'h05,8'h20}, // R7 11 AM -> 12 PM
    {8'h00, 8'h59,8'h59,8'h92,8'h04,8'h10,8'h05,8'h20, 8'h00,8'h00,8'h81,8'h04,8'h10,8'h05,8'h20}, // R7 12 PM -> 1 PM
    {8'h00, 8'h59,8'h59,8'h91,8'h04,8'h10,8'h05,8'h20, 8'h00,8'h00,8'h12,8'h05,8'h11,8'h05,8'h20}, // R7 11 PM -> 12 AM
    {8'h04, 8'h3B,8'h3B,8'h8B,8'h07,8'h1F,8'h0C,8'h63, 8'h00,8'h00,8'h0C,8'h01,8'h01,8'h01,8'h00}, // R7 R6 binary 12h wrap
    {8'h04, 8'h3B,8'h3B,8'h0C,8'h02,8'h05,8'h03,8'h0A, 8'h00,8'h00,8'h01,8'h02,8'h05,8'h03,8'h0A}, // R7 12 AM -> 1 AM
    {8'h02, 8'h30,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h31,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99}  // R5 no spurious carry
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [7:0] d);
    wr(1'b0, ix);
    wr(1'b1, d);
  endtask

  task automatic rreg(input logic [7:0] ix, output logic [7:0] v);
    wr(1'b0, ix);
    v = bus_rdata;
  endtask

  task automatic rd_strobe();
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick_and_wait();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (LEAD + 1) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state, R2 index map
    rreg(8'd0, v);  chk("R13 R2 seconds", v, 8'h00);
    rreg(8'd4, v);  chk("R13 R2 hours", v, 8'h00);
    rreg(8'd6, v);  chk("R13 R2 day of week", v, 8'h01);
    rreg(8'd7, v);  chk("R13 R2 day of month", v, 8'h01);
    rreg(8'd8, v);  chk("R13 R2 month", v, 8'h01);
    rreg(8'd9, v);  chk("R13 R2 year", v, 8'h00);
    rreg(8'd11, v); chk("R13 control B", v, 8'h02);
    rreg(8'd12, v); chk("R13 control C", v, 8'h00);
    chk("R13 irq", {7'b0, irq}, 8'h00);

    // calendar stepping table: R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      logic [119:0] t;
      string tg;
      t  = VECS[k];
      tg = t[117] ? "R6" : "R5";
      wreg(8'd11, t[119:112] | 8'h80);
      wreg(8'd0, t[111:104]);
      wreg(8'd2, t[103:96]);
      wreg(8'd4, t[95:88]);
      wreg(8'd6, t[87:80]);
      wreg(8'd7, t[79:72]);
      wreg(8'd8, t[71:64]);
      wreg(8'd9, t[63:56]);
      wreg(8'd11, t[119:112]);
      tick_and_wait();
      rreg(8'd0, v); chk($sformatf("%s seconds vec %0d", tg, k), v, t[55:48]);
      rreg(8'd2, v); chk($sformatf("%s minutes vec %0d", tg, k), v, t[47:40]);
      rreg(8'd4, v); chk($sformatf("R7 R8 hours vec %0d", k), v, t[39:32]);
      rreg(8'd6, v); chk($sformatf("R8 day of week vec %0d", k), v, t[31:24]);
      rreg(8'd7, v); chk($sformatf("R9 day of month vec %0d", k), v, t[23:16]);
      rreg(8'd8, v); chk($sformatf("R9 month vec %0d", k), v, t[15:8]);
      rreg(8'd9, v); chk($sformatf("R9 year vec %0d", k), v, t[7:0]);
    end

    // R4 hold: ticks ignored, host write lands, counting resumes
    wreg(8'd11, 8'h82);
    wreg(8'd0, 8'h20);
    wr(1'b0, 8'd10);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    chk("R4 no window while held", bus_rdata & 8'h80, 8'h00);
    repeat (LEAD + 1) @(negedge clk);
    rreg(8'd0, v); chk("R4 seconds frozen", v, 8'h20);
    wreg(8'd11, 8'h02);
    tick_and_wait();
    rreg(8'd0, v); chk("R4 resumes from written value", v, 8'h21);

    // R3 window timing, edge by edge
    wr(1'b0, 8'd10);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    chk("R3 flag rises after tick", bus_rdata & 8'h80, 8'h80);
    repeat (LEAD - 1) @(negedge clk);
    chk("R3 flag still high on last cycle", bus_rdata & 8'h80, 8'h80);
    @(negedge clk);
    chk("R3 flag low after step", bus_rdata & 8'h80, 8'h00);
    rreg(8'd0, v); chk("R3 seconds stepped at window end", v, 8'h22);
    wreg(8'd10, 8'hFF);
    rreg(8'd10, v); chk("R3 bit 7 read-only", v, 8'h7F);

    // R1 out-of-range index
    wreg(8'd20, 8'h55);
    rreg(8'd20, v); chk("R1 high index reads zero", v, 8'h00);
    rreg(8'd13, v); chk("R1 index 13 reads zero", v, 8'h00);
    rreg(8'd0, v);  chk("R1 seconds untouched", v, 8'h22);

    // R10 R12 update-ended flag
    wr(1'b0, 8'd12); rd_strobe();
    wreg(8'd1, 8'h45);
    wreg(8'd11, 8'h12);
    tick_and_wait();
    chk("R12 irq on enabled UF", {7'b0, irq}, 8'h01);
    rreg(8'd12, v); chk("R10 R12 control C after step", v, 8'h90);
    rd_strobe();
    chk("R10 control C cleared by read", bus_rdata, 8'h00);
    chk("R12 irq drops after clear", {7'b0, irq}, 8'h00);

    // R11 alarm match, R12 masking
    wreg(8'd11, 8'hA2);
    wreg(8'd0, 8'h04); wreg(8'd2, 8'h00); wreg(8'd4, 8'h00);
    wreg(8'd1, 8'h05); wreg(8'd3, 8'h00); wreg(8'd5, 8'h00);
    wreg(8'd11, 8'h22);
    tick_and_wait();
    chk("R11 irq on alarm", {7'b0, irq}, 8'h01);
    rreg(8'd12, v); chk("R11 control C with alarm", v, 8'hB0);
    rd_strobe();
    tick_and_wait();
    rreg(8'd12, v); chk("R11 no alarm on mismatch", v, 8'h10);
    chk("R12 UF alone masked", {7'b0, irq}, 8'h00);

    summary();
  end
endmodule